// File: doc/BRIEF.md
# Processor Status Flag Register

This block is the status register of a small 8-bit processor core. It keeps three arithmetic flags (zero, digit carry, carry) and two power-state bits (time-out and power-down). Each clock it decides, bit by bit, which source may change a bit: the built-in add/subtract flag generator, the flag results of other ALU operations (each with its own update enable), a register write aimed at the status register, or one of four power and watchdog event strobes.

The arithmetic flag generator takes the two operands of an add or a subtract. A subtract is formed as the first operand plus the two's complement of the second. After a subtract, carry and digit carry are high when no borrow occurred. When an instruction writes the status register and also changes flags, the flags win and the written flag bits are dropped. The power-state bits are changed only by events. Register writes never reach them.

Top module: `stat_flags_reg`

## Requirements
- R1: During and after reset, `status_q` reads 0x18: time-out (bit 4) and power-down (bit 3) are 1, and zero (bit 2), digit carry (bit 1) and carry (bit 0) are 0.
- R2: Bits 7 to 5 of `status_q` always read 0, whatever value is written.
- R3: A write (`wr_en`) with `arith_en` low and all `flag_upd` bits low loads `wr_data[2:0]` into Z, DC and C (bit 2 = Z, bit 1 = DC, bit 0 = C) on the next edge.
- R4: A write in the same cycle as `arith_en` or any `flag_upd` bit has its bits 2:0 discarded. Flags with an update take the flag value, and the other flags hold. For example, a clear with only Z updated to 1 gives 000u u1uu.
- R5: Register writes never change time-out or power-down. With no event strobe, both bits hold.
- R6: Without `arith_en` and without a write, only the flags whose `flag_upd` bit is set take the matching `flag_val` bit (same bit order as R3). The others hold.
- R7: With `arith_en` high and `arith_sub` low, the flags come from `arith_a + arith_b`: C is the carry out of bit 7, DC is the carry out of bit 3, and Z is set when the 8-bit sum is 0. `flag_upd` and `flag_val` are ignored.
- R8: With `arith_en` and `arith_sub` high, the result is `arith_a + ~arith_b + 1`. C and DC are the carries out of bits 7 and 3, so each is 0 exactly when a borrow occurred. Z is set when the result is 0.
- R9: `ev_powerup` sets time-out and power-down to 1 and leaves the arithmetic flags unchanged.
- R10: `ev_wdt_clr` sets time-out and power-down to 1.
- R11: `ev_sleep` sets time-out to 1 and clears power-down.
- R12: `ev_wdt_timeout` clears time-out and leaves power-down unchanged.
- R13: When several strobes arrive in one cycle, only the strongest acts. The order from strongest is power-up, watchdog timeout, sleep, watchdog clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| arith_en | input | 1 | Current instruction is an add or subtract whose flags come from the generator |
| arith_sub | input | 1 | 1 = subtract, 0 = add |
| arith_a | input | 8 | First operand |
| arith_b | input | 8 | Second operand (subtrahend) |
| flag_upd | input | 3 | Per-flag update enables: bit 2 Z, bit 1 DC, bit 0 C |
| flag_val | input | 3 | Flag results from other ALU operations, same bit order |
| wr_en | input | 1 | Status register is the instruction destination |
| wr_data | input | 8 | Value written to the status register |
| ev_powerup | input | 1 | Power-up event strobe |
| ev_wdt_clr | input | 1 | Watchdog clear strobe |
| ev_sleep | input | 1 | Sleep instruction strobe |
| ev_wdt_timeout | input | 1 | Watchdog timeout strobe |
| status_q | output | 8 | Status register value |

## Verification
The bench builds the block with its defaults: 8-bit operands, a digit carry taken at the 4-bit boundary, and subtract carry read as "no borrow". With 8-bit operands, a few chosen vectors reach the nibble carry, the full wrap to zero and both borrow cases. A long stretch of generated stimulus then exercises every mix of write, flag enables, arithmetic and overlapping event strobes, and a behavioural model checks `status_q` against the expected value on every clock.

// File: rtl/sflag_pkg.sv
package sflag_pkg;

   localparam int NFLAG   = 3;
   localparam int C_POS   = 0;
   localparam int DC_POS  = 1;
   localparam int Z_POS   = 2;
   localparam int PD_POS  = 3;
   localparam int TO_POS  = 4;
   localparam int USED_W  = 5;

   typedef logic [NFLAG-1:0] flag_vec_t;

   typedef enum logic [2:0] {
      PEV_NONE,
      PEV_POWERUP,
      PEV_TIMEOUT,
      PEV_SLEEP,
      PEV_WDTCLR
   } pwr_ev_e;

endpackage

// File: rtl/sflag_arith.sv
module sflag_arith
   import sflag_pkg::*;
#(
   parameter int DATA_W             = 8,
   parameter int NIB_W              = 4,
   parameter bit SUB_C_IS_NOBORROW  = 1'b1
) (
   input  logic              sub,
   input  logic [DATA_W-1:0] opa,
   input  logic [DATA_W-1:0] opb,
   output flag_vec_t         flags
);

   localparam int FULL_W = DATA_W + 1;
   localparam int LOW_W  = NIB_W + 1;

   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("sflag_arith: DATA_W must be at least 2");
      end
      if (NIB_W < 1 || NIB_W >= DATA_W) begin : g_bad_nib
         $error("sflag_arith: NIB_W must lie inside the operand");
      end
   endgenerate

   logic [DATA_W-1:0] opb_eff;
   logic [FULL_W-1:0] full_sum;
   logic [LOW_W-1:0]  low_sum;
   logic              raw_c;
   logic              raw_dc;
   logic              res_zero;

   always_comb begin
      opb_eff  = sub ? ~opb : opb;
      full_sum = {1'b0, opa} + {1'b0, opb_eff} + {{DATA_W{1'b0}}, sub};
      low_sum  = {1'b0, opa[NIB_W-1:0]} + {1'b0, opb_eff[NIB_W-1:0]}
               + {{NIB_W{1'b0}}, sub};
      raw_c    = full_sum[DATA_W];
      raw_dc   = low_sum[NIB_W];
      res_zero = (full_sum[DATA_W-1:0] == '0);
   end

   generate
      if (SUB_C_IS_NOBORROW) begin : g_noborrow
         always_comb begin
            flags         = '0;
            flags[Z_POS]  = res_zero;
            flags[DC_POS] = raw_dc;
            flags[C_POS]  = raw_c;
         end
      end else begin : g_borrow
         always_comb begin
            flags         = '0;
            flags[Z_POS]  = res_zero;
            flags[DC_POS] = sub ? ~raw_dc : raw_dc;
            flags[C_POS]  = sub ? ~raw_c  : raw_c;
         end
      end
   endgenerate

   always_comb begin
      if (!sub && opa == '0 && opb == '0)
         AST_ADD_ZERO: assert (flags[Z_POS] && !flags[C_POS] && !flags[DC_POS]); // R7
      if (sub && opa == opb && !$isunknown(opa))
         AST_SUB_EQUAL: assert (flags[Z_POS] && (flags[C_POS] == SUB_C_IS_NOBORROW)); // R8
   end

endmodule

// File: rtl/sflag_flagsel.sv
module sflag_flagsel
   import sflag_pkg::*;
(
   input  flag_vec_t cur,
   input  logic      arith_en,
   input  flag_vec_t arith_flags,
   input  flag_vec_t upd,
   input  flag_vec_t ext_val,
   input  logic      wr_en,
   input  flag_vec_t wr_val,
   output flag_vec_t nxt
);

   logic any_flag_op;
   logic wr_takes;

   always_comb begin
      any_flag_op = arith_en || (|upd);
      wr_takes    = wr_en && !any_flag_op;
   end

   generate
      for (genvar i = 0; i < NFLAG; i++) begin : g_bit
         always_comb begin
            if (arith_en)
               nxt[i] = arith_flags[i];
            else if (upd[i])
               nxt[i] = ext_val[i];
            else if (wr_takes)
               nxt[i] = wr_val[i];
            else
               nxt[i] = cur[i];
         end
      end
   endgenerate

endmodule

// File: rtl/sflag_pwr.sv
module sflag_pwr
   import sflag_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic ev_powerup,
   input  logic ev_wdt_clr,
   input  logic ev_sleep,
   input  logic ev_wdt_timeout,
   output logic to_q,
   output logic pd_q
);

   pwr_ev_e ev_sel;
   logic    to_d;
   logic    pd_d;

   always_comb begin
      if (ev_powerup)          ev_sel = PEV_POWERUP;
      else if (ev_wdt_timeout) ev_sel = PEV_TIMEOUT;
      else if (ev_sleep)       ev_sel = PEV_SLEEP;
      else if (ev_wdt_clr)     ev_sel = PEV_WDTCLR;
      else                     ev_sel = PEV_NONE;
   end

   always_comb begin
      to_d = to_q;
      pd_d = pd_q;
      case (ev_sel)
         PEV_POWERUP: begin to_d = 1'b1; pd_d = 1'b1; end
         PEV_TIMEOUT: begin to_d = 1'b0; end
         PEV_SLEEP:   begin to_d = 1'b1; pd_d = 1'b0; end
         PEV_WDTCLR:  begin to_d = 1'b1; pd_d = 1'b1; end
         default:     ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         to_q <= 1'b1;
         pd_q <= 1'b1;
      end else begin
         to_q <= to_d;
         pd_q <= pd_d;
      end
   end

   AST_POWERUP_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      ev_powerup |=> (to_q && pd_q)); // R9
   AST_TIMEOUT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_wdt_timeout && !ev_powerup) |=> (!to_q && pd_q == $past(pd_q))); // R12
   AST_SLEEP_PD: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_sleep && !ev_powerup && !ev_wdt_timeout) |=> (to_q && !pd_q)); // R11
   AST_PWR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(ev_powerup || ev_wdt_clr || ev_sleep || ev_wdt_timeout) |=> ($stable(to_q) && $stable(pd_q))); // R5

endmodule

// File: rtl/stat_flags_reg.sv
module stat_flags_reg
   import sflag_pkg::*;
#(
   parameter int ST_W              = 8,
   parameter int DATA_W            = 8,
   parameter int NIB_W             = 4,
   parameter bit SUB_C_IS_NOBORROW = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              arith_en,
   input  logic              arith_sub,
   input  logic [DATA_W-1:0] arith_a,
   input  logic [DATA_W-1:0] arith_b,
   input  logic [NFLAG-1:0]  flag_upd,
   input  logic [NFLAG-1:0]  flag_val,
   input  logic              wr_en,
   input  logic [ST_W-1:0]   wr_data,
   input  logic              ev_powerup,
   input  logic              ev_wdt_clr,
   input  logic              ev_sleep,
   input  logic              ev_wdt_timeout,
   output logic [ST_W-1:0]   status_q
);

   localparam int PAD_W = ST_W - USED_W;

   generate
      if (ST_W <= USED_W) begin : g_bad_st_w
         $error("stat_flags_reg: ST_W must exceed the used bit count");
      end
   endgenerate

   flag_vec_t flags_q;
   flag_vec_t flags_d;
   flag_vec_t arith_flags;
   logic      to_q;
   logic      pd_q;
   logic      wr_data_unused;

   assign wr_data_unused = ^wr_data[ST_W-1:NFLAG];

   sflag_arith #(
      .DATA_W            (DATA_W),
      .NIB_W             (NIB_W),
      .SUB_C_IS_NOBORROW (SUB_C_IS_NOBORROW)
   ) arith_i (
      .sub   (arith_sub),
      .opa   (arith_a),
      .opb   (arith_b),
      .flags (arith_flags)
   );

   sflag_flagsel flagsel_i (
      .cur         (flags_q),
      .arith_en    (arith_en),
      .arith_flags (arith_flags),
      .upd         (flag_upd),
      .ext_val     (flag_val),
      .wr_en       (wr_en),
      .wr_val      (wr_data[NFLAG-1:0]),
      .nxt         (flags_d)
   );

   sflag_pwr pwr_i (
      .clk            (clk),
      .rst_n          (rst_n),
      .ev_powerup     (ev_powerup),
      .ev_wdt_clr     (ev_wdt_clr),
      .ev_sleep       (ev_sleep),
      .ev_wdt_timeout (ev_wdt_timeout),
      .to_q           (to_q),
      .pd_q           (pd_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags_q <= '0;
      else        flags_q <= flags_d;
   end

   always_comb begin
      status_q         = '0;
      status_q[TO_POS] = to_q;
      status_q[PD_POS] = pd_q;
      status_q[Z_POS]  = flags_q[Z_POS];
      status_q[DC_POS] = flags_q[DC_POS];
      status_q[C_POS]  = flags_q[C_POS];
   end

   AST_WR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !arith_en && flag_upd == '0) |=> (status_q[NFLAG-1:0] == $past(wr_data[NFLAG-1:0]))); // R3
   AST_WR_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !arith_en && flag_upd != '0) |=>
         (status_q[NFLAG-1:0] == (($past(flag_upd) & $past(flag_val)) | (~$past(flag_upd) & $past(flags_q))))); // R4
   AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en && !arith_en && flag_upd == '0) |=> $stable(flags_q)); // R6
   AST_WR_NO_PWR: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !(ev_powerup || ev_wdt_clr || ev_sleep || ev_wdt_timeout)) |=>
         (status_q[TO_POS] == $past(to_q) && status_q[PD_POS] == $past(pd_q))); // R5

   if (PAD_W < 0) begin : g_never
   end

endmodule

// File: tb/stat_flags_reg_tb_top.sv
`timescale 1ns/1ps
module stat_flags_reg_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       arith_en = 1'b0;
   logic       arith_sub = 1'b0;
   logic [7:0] arith_a = 8'h00;
   logic [7:0] arith_b = 8'h00;
   logic [2:0] flag_upd = 3'b000;
   logic [2:0] flag_val = 3'b000;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic       ev_powerup = 1'b0;
   logic       ev_wdt_clr = 1'b0;
   logic       ev_sleep = 1'b0;
   logic       ev_wdt_timeout = 1'b0;
   logic [7:0] status_q;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;
   bit cmp_on = 1'b0;
   string cur_tag = "R1";
   logic [7:0] exp_st = 8'h18;

   always #2 clk = ~clk;

   stat_flags_reg dut_i (
      .clk(clk), .rst_n(rst_n), .arith_en(arith_en), .arith_sub(arith_sub),
      .arith_a(arith_a), .arith_b(arith_b), .flag_upd(flag_upd), .flag_val(flag_val),
      .wr_en(wr_en), .wr_data(wr_data), .ev_powerup(ev_powerup), .ev_wdt_clr(ev_wdt_clr),
      .ev_sleep(ev_sleep), .ev_wdt_timeout(ev_wdt_timeout), .status_q(status_q)
   );

   function automatic logic [7:0] model_next(logic [7:0] old);
      int to, pd, z, dc, c, sum, lo, bb;
      to = old[4]; pd = old[3]; z = old[2]; dc = old[1]; c = old[0];
      if (ev_powerup) begin to = 1; pd = 1; end
      else if (ev_wdt_timeout) to = 0;
      else if (ev_sleep) begin to = 1; pd = 0; end
      else if (ev_wdt_clr) begin to = 1; pd = 1; end
      if (arith_en) begin
         if (arith_sub) begin
            bb  = 255 - int'(arith_b);
            sum = int'(arith_a) + bb + 1;
            lo  = (int'(arith_a) % 16) + (bb % 16) + 1;
         end else begin
            sum = int'(arith_a) + int'(arith_b);
            lo  = (int'(arith_a) % 16) + (int'(arith_b) % 16);
         end
         c  = (sum >= 256) ? 1 : 0;
         dc = (lo >= 16) ? 1 : 0;
         z  = ((sum % 256) == 0) ? 1 : 0;
      end else if (flag_upd != 3'b000) begin
         if (flag_upd[0]) c  = flag_val[0];
         if (flag_upd[1]) dc = flag_val[1];
         if (flag_upd[2]) z  = flag_val[2];
      end else if (wr_en) begin
         c = wr_data[0]; dc = wr_data[1]; z = wr_data[2];
      end
      return {3'b000, 1'(to), 1'(pd), 1'(z), 1'(dc), 1'(c)};
   endfunction

   always @(posedge clk) begin
      if (!rst_n) exp_st = 8'h18;
      else        exp_st = model_next(exp_st);
   end

   always @(negedge clk) begin
      if (cmp_on && !done) begin
         checks++;
         if (status_q !== exp_st) begin
            failures++;
            $display("FAIL %s model compare: actual=%02h expected=%02h", cur_tag, status_q, exp_st);
         end
      end
   end

   task automatic check_lit(input logic [7:0] expv, input string tag);
      checks++;
      if (status_q !== expv) begin
         failures++;
         $display("FAIL %s: actual=%02h expected=%02h", tag, status_q, expv);
      end
   endtask

   task automatic idle();
      arith_en = 0; arith_sub = 0; flag_upd = 0; flag_val = 0; wr_en = 0; wr_data = 0;
      ev_powerup = 0; ev_wdt_clr = 0; ev_sleep = 0; ev_wdt_timeout = 0;
   endtask

   task automatic tick();
      @(negedge clk);
      idle();
   endtask

   initial begin
      idle();
      repeat (3) @(negedge clk);
      check_lit(8'h18, "R1 in reset");
      rst_n = 1'b1;
      cmp_on = 1'b1;
      @(negedge clk);
      check_lit(8'h18, "R1 after reset");

      cur_tag = "R3";
      wr_en = 1; wr_data = 8'hFF; tick();
      check_lit(8'h1F, "R2 R3 R5 write FF");
      wr_en = 1; wr_data = 8'h01; tick();
      check_lit(8'h19, "R3 write 01");

      cur_tag = "R4";
      wr_en = 1; wr_data = 8'h00; flag_upd = 3'b100; flag_val = 3'b100; tick();
      check_lit(8'h1D, "R4 clear 000uu1uu");
      wr_en = 1; wr_data = 8'h07; arith_en = 1; arith_a = 8'h01; arith_b = 8'h02; tick();
      check_lit(8'h18, "R4 write lost to add");

      cur_tag = "R6";
      flag_upd = 3'b010; flag_val = 3'b111; tick();
      check_lit(8'h1A, "R6 only DC updates");

      cur_tag = "R8";
      arith_en = 1; arith_sub = 1; arith_a = 8'h10; arith_b = 8'h20; tick();
      check_lit(8'h1A, "R8 subtract with borrow");
      arith_en = 1; arith_sub = 1; arith_a = 8'h55; arith_b = 8'h55; tick();
      check_lit(8'h1F, "R8 subtract equal");
      arith_en = 1; arith_sub = 1; arith_a = 8'h03; arith_b = 8'h04; tick();
      check_lit(8'h18, "R8 nibble borrow");

      cur_tag = "R7";
      arith_en = 1; arith_a = 8'h88; arith_b = 8'h88; flag_upd = 3'b111; flag_val = 3'b000; tick();
      check_lit(8'h1B, "R7 add carries");
      arith_en = 1; arith_a = 8'hFF; arith_b = 8'h01; tick();
      check_lit(8'h1F, "R7 add wraps to zero");

      cur_tag = "R11";
      ev_sleep = 1; tick();
      check_lit(8'h17, "R11 sleep");
      cur_tag = "R5";
      wr_en = 1; wr_data = 8'hF8; tick();
      check_lit(8'h10, "R5 write ignores TO PD");
      cur_tag = "R12";
      ev_wdt_timeout = 1; tick();
      check_lit(8'h00, "R12 timeout");
      cur_tag = "R10";
      ev_wdt_clr = 1; tick();
      check_lit(8'h18, "R10 watchdog clear");
      cur_tag = "R13";
      ev_wdt_timeout = 1; ev_sleep = 1; ev_wdt_clr = 1; tick();
      check_lit(8'h08, "R13 timeout beats sleep and clear");
      ev_sleep = 1; ev_wdt_clr = 1; tick();
      check_lit(8'h10, "R13 sleep beats clear");
      cur_tag = "R9";
      wr_en = 1; wr_data = 8'h05; tick();
      ev_powerup = 1; ev_wdt_timeout = 1; ev_sleep = 1; tick();
      check_lit(8'h1D, "R9 R13 power-up wins, flags kept");

      cur_tag = "R3 R4 R6 R7 R8 R9 R10 R11 R12 R13 mixed";
      begin
         int unsigned seed;
         seed = 32'h1234_5678;
         for (int i = 0; i < 300; i++) begin
            seed = seed * 32'd1664525 + 32'd1013904223;
            arith_en       = seed[31] & seed[30];
            arith_sub      = seed[29];
            arith_a        = seed[23:16];
            arith_b        = seed[15:8];
            flag_upd       = seed[28] ? seed[7:5] : 3'b000;
            flag_val       = seed[4:2];
            wr_en          = seed[27];
            wr_data        = {seed[11:8], seed[1:0], seed[26:25]};
            ev_powerup     = (seed[24:21] == 4'd0);
            ev_wdt_timeout = (seed[20:18] == 3'd1);
            ev_sleep       = (seed[17:15] == 3'd2);
            ev_wdt_clr     = (seed[14:12] == 3'd3);
            tick();
         end
      end
      tick();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         failures++;
         $display("FAIL watchdog R1: actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule